// File: doc/BRIEF.md
# Software Interrupt Source Tracker

This block records, for every target processor and every software interrupt number, which processors raised that interrupt. Each (target, number) pair holds a vector with one bit per source processor. The pending flag of the pair is the OR of that vector. The flag falls only when the last source bit is cleared.

Three paths change the vectors. A generation request adds the requester's bit to every target named in its mask. A byte-wide register port holds a clear-by-source window. In that window a byte write removes the source bits set in the data byte, for one interrupt number on the accessing processor. An acknowledge names a target and an interrupt number. It reports the lowest-numbered source still set and removes that source only. A build parameter selects a legacy variant that has no clear window. In that variant, accesses to the window are reported as bad-register accesses.

Top module: `sgi_src_tracker`

## Requirements
- R1: A generation request sets bit `gen_src` of the vector for `gen_id` on every target whose bit is set in `gen_targets`. The matching `pend` bit is high after the next clock edge. `pend` bit index is `target*NUM_SGI + id`.
- R2: A write to offset `0xF10 + n` (n below NUM_SGI) clears, in the vector for number n on processor `reg_cpu`, every source bit whose bit is set in `reg_wdata`. Bit k of the byte stands for source processor k.
- R3: After a clear or an acknowledge, `pend` stays high while any source bit of the entry remains. It drops at the edge where the vector becomes zero.
- R4: An acknowledge on an entry with a non-zero vector sets `ack_done` and `ack_hit` one cycle later. In that cycle `ack_src` holds the lowest set source index. Only that source bit is cleared.
- R5: An acknowledge on an empty entry gives `ack_done`=1, `ack_hit`=0 and `ack_src`=0 one cycle later. It changes no state.
- R6: When a generation request and a clear or acknowledge hit the same entry in one cycle, the generated source bit is set afterwards.
- R7: A read of offset `0xF10 + n` returns the vector for number n on `reg_cpu` in `reg_rdata` one cycle later. It returns the value held before any same-cycle update. All other reads return 0.
- R8: A write to any offset in `0xF00`–`0xF0F` raises `reg_bad` for one cycle, one cycle later, and changes no state.
- R9: With `LEGACY`=1, any read or write in `0xF10`–`0xF1F` raises `reg_bad` one cycle later, returns 0 and changes no state.
- R10: Synchronous reset clears all vectors, `pend`, `ack_done`, `ack_hit`, `ack_src`, `reg_rdata` and `reg_bad`.
- R11: Register accesses outside `0xF00`–`0xF1F` are ignored: no state change, `reg_bad` stays 0 and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_valid | input | 1 | Generation request |
| gen_src | input | CPU_W | Requesting processor |
| gen_targets | input | NUM_CPU | Target processor mask |
| gen_id | input | SGI_W | Interrupt number to raise |
| ack_valid | input | 1 | Acknowledge request |
| ack_cpu | input | CPU_W | Acknowledging target processor |
| ack_id | input | SGI_W | Interrupt number acknowledged |
| ack_done | output | 1 | Acknowledge response valid |
| ack_hit | output | 1 | A source was found and consumed |
| ack_src | output | CPU_W | Reported source processor |
| reg_wr | input | 1 | Register byte write |
| reg_rd | input | 1 | Register byte read |
| reg_off | input | 12 | Byte offset of the access |
| reg_wdata | input | 8 | Write data |
| reg_cpu | input | CPU_W | Processor performing the access |
| reg_rdata | output | 8 | Read data |
| reg_bad | output | 1 | Bad-register access flag |
| pend | output | NUM_CPU*NUM_SGI | Pending flag per target and number |

## Verification
A corrupted source bit shows at the ports in one of three ways. It can leave a `pend` bit high after the last expected clear. It can make an acknowledge report the wrong lowest source. It can make a window read return a wrong byte. Each of these is visible one cycle after the stimulus that exposes it. A stale bit stays hidden until that entry is read, acknowledged or fully cleared. For that reason the random stimulus uses only a few interrupt numbers, so that every entry is touched often. It also reads the window on every processor.

// File: rtl/sgi_trk_pkg.sv
package sgi_trk_pkg;
  // Offset upper nibble-pair codes: the word-only range and the clear window.
  localparam logic [7:0] WORD_ONLY_PAGE = 8'hF0;
  localparam logic [7:0] CLR_WIN_PAGE   = 8'hF1;

  typedef enum logic [1:0] {
    REGION_OTHER,
    REGION_WORD_ONLY,
    REGION_CLR_WIN
  } region_e;
endpackage

// File: rtl/sgi_trk_decode.sv
module sgi_trk_decode
  import sgi_trk_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int SGI_W   = 4,
  parameter bit LEGACY  = 1'b0
) (
  input  logic [11:0]      off,
  input  logic             wr,
  input  logic             rd,
  output logic             win_wr,
  output logic             win_rd,
  output logic [SGI_W-1:0] win_idx,
  output logic             bad
);
  region_e    region;
  logic [3:0] rel;
  logic       in_range;

  assign rel      = off[3:0];
  assign in_range = ({1'b0, rel} < 5'(NUM_SGI));
  assign win_idx  = rel[SGI_W-1:0];

  always_comb begin
    if (off[11:4] == WORD_ONLY_PAGE)    region = REGION_WORD_ONLY;
    else if (off[11:4] == CLR_WIN_PAGE) region = REGION_CLR_WIN;
    else                                region = REGION_OTHER;
  end

  generate
    if (LEGACY) begin : g_legacy
      assign win_wr = 1'b0;
      assign win_rd = 1'b0;
      assign bad    = (wr && region == REGION_WORD_ONLY) ||
                      ((wr || rd) && region == REGION_CLR_WIN);
    end else begin : g_full
      assign win_wr = wr && region == REGION_CLR_WIN && in_range;
      assign win_rd = rd && region == REGION_CLR_WIN && in_range;
      assign bad    = wr && region == REGION_WORD_ONLY;
    end
  endgenerate
endmodule

// File: rtl/sgi_trk_lowest.sv
module sgi_trk_lowest #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/sgi_trk_entry.sv
module sgi_trk_entry #(
  parameter int NUM_CPU = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CPU-1:0] set_bits,
  input  logic [NUM_CPU-1:0] clr_bits,
  output logic [NUM_CPU-1:0] vec_q,
  output logic               pend_q
);
  logic [NUM_CPU-1:0] vec_d;

  // Sets are applied after clears so a same-cycle raise survives.
  assign vec_d = (vec_q & ~clr_bits) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      vec_q  <= vec_d;
      pend_q <= |vec_d;
    end
  end
endmodule

// File: rtl/sgi_src_tracker.sv
module sgi_src_tracker #(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  parameter bit LEGACY  = 1'b0,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SGI_W  = (NUM_SGI > 1) ? $clog2(NUM_SGI) : 1,
  localparam int NUM_ENT = NUM_CPU * NUM_SGI
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gen_valid,
  input  logic [CPU_W-1:0]   gen_src,
  input  logic [NUM_CPU-1:0] gen_targets,
  input  logic [SGI_W-1:0]   gen_id,
  input  logic               ack_valid,
  input  logic [CPU_W-1:0]   ack_cpu,
  input  logic [SGI_W-1:0]   ack_id,
  output logic               ack_done,
  output logic               ack_hit,
  output logic [CPU_W-1:0]   ack_src,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [11:0]        reg_off,
  input  logic [7:0]         reg_wdata,
  input  logic [CPU_W-1:0]   reg_cpu,
  output logic [7:0]         reg_rdata,
  output logic               reg_bad,
  output logic [NUM_ENT-1:0] pend
);
  // NUM_CPU and NUM_SGI are powers of two; NUM_CPU <= 8, NUM_SGI <= 16.
  localparam int ENT_W = CPU_W + SGI_W;

  logic               win_wr, win_rd, bad_d;
  logic [SGI_W-1:0]   win_idx;
  logic [NUM_CPU-1:0] vec [NUM_ENT];
  logic [NUM_CPU-1:0] rd_vec, ack_vec, ack_clr, wr_clr, gen_bit;
  logic [CPU_W-1:0]   pick_idx;
  logic               pick_any;
  logic [ENT_W-1:0]   rd_ent, ack_ent;

  sgi_trk_decode #(
    .NUM_SGI (NUM_SGI),
    .SGI_W   (SGI_W),
    .LEGACY  (LEGACY)
  ) u_decode (
    .off     (reg_off),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .win_wr  (win_wr),
    .win_rd  (win_rd),
    .win_idx (win_idx),
    .bad     (bad_d)
  );

  assign rd_ent  = {reg_cpu, win_idx};
  assign ack_ent = {ack_cpu, ack_id};
  assign rd_vec  = vec[rd_ent];
  assign ack_vec = vec[ack_ent];

  sgi_trk_lowest #(
    .W  (NUM_CPU),
    .IW (CPU_W)
  ) u_pick (
    .vec (ack_vec),
    .idx (pick_idx),
    .any (pick_any)
  );

  assign ack_clr = (ack_valid && pick_any) ? (NUM_CPU'(1) << pick_idx) : '0;
  assign wr_clr  = reg_wdata[NUM_CPU-1:0];
  assign gen_bit = NUM_CPU'(1) << gen_src;

  generate
    for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
      for (genvar s = 0; s < NUM_SGI; s++) begin : g_sgi
        localparam int E = t * NUM_SGI + s;
        logic [NUM_CPU-1:0] set_bits, clr_bits;
        logic               wr_sel, ack_sel;

        assign wr_sel   = win_wr && reg_cpu == CPU_W'(t) && win_idx == SGI_W'(s);
        assign ack_sel  = ack_valid && ack_cpu == CPU_W'(t) && ack_id == SGI_W'(s);
        assign set_bits = (gen_valid && gen_targets[t] && gen_id == SGI_W'(s))
                          ? gen_bit : '0;
        assign clr_bits = (wr_sel ? wr_clr : '0) | (ack_sel ? ack_clr : '0);

        sgi_trk_entry #(
          .NUM_CPU (NUM_CPU)
        ) u_entry (
          .clk      (clk),
          .rst      (rst),
          .set_bits (set_bits),
          .clr_bits (clr_bits),
          .vec_q    (vec[E]),
          .pend_q   (pend[E])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_done  <= 1'b0;
      ack_hit   <= 1'b0;
      ack_src   <= '0;
      reg_rdata <= '0;
      reg_bad   <= 1'b0;
    end else begin
      ack_done  <= ack_valid;
      ack_hit   <= ack_valid && pick_any;
      ack_src   <= (ack_valid && pick_any) ? pick_idx : '0;
      reg_rdata <= win_rd ? 8'(rd_vec) : 8'h00;
      reg_bad   <= bad_d;
    end
  end
endmodule

// File: rtl/sgi_src_tracker_chk.sv
module sgi_src_tracker_chk #(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  parameter bit LEGACY  = 1'b0,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SGI_W  = (NUM_SGI > 1) ? $clog2(NUM_SGI) : 1,
  localparam int NUM_ENT = NUM_CPU * NUM_SGI
) (
  input logic               clk,
  input logic               rst,
  input logic               gen_valid,
  input logic [CPU_W-1:0]   gen_src,
  input logic [NUM_CPU-1:0] gen_targets,
  input logic [SGI_W-1:0]   gen_id,
  input logic               ack_valid,
  input logic [CPU_W-1:0]   ack_cpu,
  input logic [SGI_W-1:0]   ack_id,
  input logic               ack_done,
  input logic               ack_hit,
  input logic [CPU_W-1:0]   ack_src,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [11:0]        reg_off,
  input logic [7:0]         reg_wdata,
  input logic [CPU_W-1:0]   reg_cpu,
  input logic [7:0]         reg_rdata,
  input logic               reg_bad,
  input logic [NUM_ENT-1:0] pend
);
  logic [SGI_W-1:0] gen_id_q;
  always_ff @(posedge clk) gen_id_q <= gen_id;

  a_r8_word_write_bad: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_off[11:4] == 8'hF0) |=> reg_bad);

  a_r11_quiet_port: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !reg_rd) |=> (!reg_bad && reg_rdata == 8'h00));

  a_r5_empty_ack: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !pend[{ack_cpu, ack_id}]) |=> (ack_done && !ack_hit && ack_src == '0));

  a_r4_ack_response: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> ack_done);

  generate
    if (LEGACY) begin : g_leg
      a_r9_legacy_window_bad: assert property (@(posedge clk) disable iff (rst)
        ((reg_wr || reg_rd) && reg_off[11:4] == 8'hF1) |=> (reg_bad && reg_rdata == 8'h00));
    end
    for (genvar t = 0; t < NUM_CPU; t++) begin : g_t
      a_r1_gen_sets: assert property (@(posedge clk) disable iff (rst)
        (gen_valid && gen_targets[t]) |=> pend[t * NUM_SGI + int'(gen_id_q)]);
    end
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_e
      a_r3_no_spurious_rise: assert property (@(posedge clk) disable iff (rst)
        (!pend[e] && !gen_valid) |=> !pend[e]);
    end
  endgenerate
endmodule

bind sgi_src_tracker sgi_src_tracker_chk #(
  .NUM_CPU (NUM_CPU),
  .NUM_SGI (NUM_SGI),
  .LEGACY  (LEGACY)
) u_chk (.*);

// File: tb/test_sgi_src_tracker.sv
module test_sgi_src_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NS = 16;
  localparam int CW = 3;
  localparam int SW = 4;
  localparam int NE = NC * NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          gen_valid = 0, ack_valid = 0, reg_wr = 0, reg_rd = 0;
  logic [CW-1:0] gen_src = 0, ack_cpu = 0, reg_cpu = 0;
  logic [NC-1:0] gen_targets = 0;
  logic [SW-1:0] gen_id = 0, ack_id = 0;
  logic [11:0]   reg_off = 0;
  logic [7:0]    reg_wdata = 0;

  logic [1:0]    ack_done_o, ack_hit_o, reg_bad_o;
  logic [CW-1:0] ack_src_o [2];
  logic [7:0]    rdata_o [2];
  logic [NE-1:0] pend_o [2];

  int total = 0;
  int bad = 0;
  logic [NC-1:0] mdl [2][NC][NS];

  sgi_src_tracker #(.NUM_CPU(NC), .NUM_SGI(NS), .LEGACY(1'b0)) i_sgi_src_tracker (
    .clk(clk), .rst(rst), .gen_valid(gen_valid), .gen_src(gen_src),
    .gen_targets(gen_targets), .gen_id(gen_id), .ack_valid(ack_valid),
    .ack_cpu(ack_cpu), .ack_id(ack_id), .ack_done(ack_done_o[0]),
    .ack_hit(ack_hit_o[0]), .ack_src(ack_src_o[0]), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .reg_cpu(reg_cpu), .reg_rdata(rdata_o[0]), .reg_bad(reg_bad_o[0]),
    .pend(pend_o[0]));

  sgi_src_tracker #(.NUM_CPU(NC), .NUM_SGI(NS), .LEGACY(1'b1)) i_sgi_src_tracker_legacy (
    .clk(clk), .rst(rst), .gen_valid(gen_valid), .gen_src(gen_src),
    .gen_targets(gen_targets), .gen_id(gen_id), .ack_valid(ack_valid),
    .ack_cpu(ack_cpu), .ack_id(ack_id), .ack_done(ack_done_o[1]),
    .ack_hit(ack_hit_o[1]), .ack_src(ack_src_o[1]), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .reg_cpu(reg_cpu), .reg_rdata(rdata_o[1]), .reg_bad(reg_bad_o[1]),
    .pend(pend_o[1]));

  function automatic int lowest(logic [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(string tag, string what, logic [NE-1:0] act, logic [NE-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    gen_valid = 0; ack_valid = 0; reg_wr = 0; reg_rd = 0;
  endtask

  // One clock: compute expectations from the model, clock, compare, advance.
  task automatic tick(string tag);
    logic [NC-1:0] nxt [2][NC][NS];
    logic e_hit [2];
    int   e_src [2];
    logic [7:0] e_rd [2];
    logic e_bad [2];
    logic [NE-1:0] e_pend;
    logic word, win;
    int   idx;
    word = (reg_off[11:4] == 8'hF0);
    win  = (reg_off[11:4] == 8'hF1);
    idx  = int'(reg_off[3:0]);
    for (int l = 0; l < 2; l++) begin
      logic [NC-1:0] av;
      av = mdl[l][ack_cpu][ack_id];
      e_hit[l] = ack_valid && (av != 0);
      e_src[l] = e_hit[l] ? lowest(av) : 0;
      e_bad[l] = (reg_wr && word) || ((reg_wr || reg_rd) && win && l == 1);
      e_rd[l]  = (reg_rd && win && l == 0) ? 8'(mdl[l][reg_cpu][idx]) : 8'h00;
      for (int t = 0; t < NC; t++) begin
        for (int s = 0; s < NS; s++) begin
          logic [NC-1:0] v;
          v = mdl[l][t][s];
          if (reg_wr && win && l == 0 && int'(reg_cpu) == t && idx == s) v = v & ~reg_wdata;
          if (e_hit[l] && int'(ack_cpu) == t && int'(ack_id) == s) v = v & ~(NC'(1) << e_src[l]);
          if (gen_valid && gen_targets[t] && int'(gen_id) == s) v = v | (NC'(1) << gen_src);
          nxt[l][t][s] = v;
        end
      end
    end
    @(posedge clk);
    #1;
    for (int l = 0; l < 2; l++) begin
      for (int t = 0; t < NC; t++)
        for (int s = 0; s < NS; s++) e_pend[t * NS + s] = (nxt[l][t][s] != 0);
      chk(tag, l ? "legacy pend" : "pend", pend_o[l], e_pend);
      chk(tag, "ack_done", NE'(ack_done_o[l]), NE'(ack_valid));
      chk(tag, "ack_hit", NE'(ack_hit_o[l]), NE'(e_hit[l]));
      chk(tag, "ack_src", NE'(ack_src_o[l]), NE'(e_src[l]));
      chk(tag, l ? "legacy rdata" : "rdata", NE'(rdata_o[l]), NE'(e_rd[l]));
      chk(tag, l ? "legacy bad" : "bad", NE'(reg_bad_o[l]), NE'(e_bad[l]));
    end
    mdl = nxt;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    for (int l = 0; l < 2; l++)
      for (int t = 0; t < NC; t++)
        for (int s = 0; s < NS; s++) mdl[l][t][s] = '0;
    // R10: reset state, with stimulus applied during reset.
    gen_valid = 1; gen_targets = '1; ack_valid = 1; reg_rd = 1; reg_off = 12'hF00; reg_wr = 1;
    repeat (3) @(posedge clk);
    #1;
    for (int l = 0; l < 2; l++) begin
      chk("R10", "reset pend", pend_o[l], '0);
      chk("R10", "reset outs", NE'({ack_done_o[l], ack_hit_o[l], ack_src_o[l], rdata_o[l], reg_bad_o[l]}), '0);
    end
    @(negedge clk);
    idle();
    rst = 0;

    // R1: two sources raise number 7 at target 1.
    gen_valid = 1; gen_src = 5; gen_targets = 8'b0000_0010; gen_id = 7; tick("R1");
    gen_valid = 1; gen_src = 2; gen_targets = 8'b0000_0010; gen_id = 7; tick("R1");
    // R7 R9: read the vector back (0x24); legacy reports bad.
    reg_rd = 1; reg_off = 12'hF17; reg_cpu = 1; tick("R7 R9 read");
    // R4: lowest source 2 reported, pend stays (R3).
    ack_valid = 1; ack_cpu = 1; ack_id = 7; tick("R4 R3 ack");
    // R2 R3: clearing source 5 drops the flag; legacy keeps it.
    reg_wr = 1; reg_off = 12'hF17; reg_cpu = 1; reg_wdata = 8'h20; tick("R2 R3 R9 clear");
    // R5: acknowledge of an empty entry.
    ack_valid = 1; ack_cpu = 1; ack_id = 7; tick("R5 empty ack");
    // R6: raise and clear together on one entry.
    gen_valid = 1; gen_src = 3; gen_targets = 8'b0000_0001; gen_id = 2; tick("R1");
    gen_valid = 1; gen_src = 4; gen_targets = 8'b0000_0001; gen_id = 2;
    reg_wr = 1; reg_off = 12'hF12; reg_cpu = 0; reg_wdata = 8'hFF; tick("R6 set wins clear");
    gen_valid = 1; gen_src = 4; gen_targets = 8'b0000_0001; gen_id = 2;
    ack_valid = 1; ack_cpu = 0; ack_id = 2; tick("R6 set wins ack");
    reg_rd = 1; reg_off = 12'hF12; reg_cpu = 0; tick("R6 R7 readback");
    // R8: word-only range rejects byte writes.
    reg_wr = 1; reg_off = 12'hF05; reg_wdata = 8'hFF; tick("R8 word range");
    reg_rd = 1; reg_off = 12'hF05; tick("R8 read word range");
    // R11: other offsets ignored.
    reg_wr = 1; reg_off = 12'hF20; reg_wdata = 8'hFF; tick("R11 write other");
    reg_rd = 1; reg_off = 12'h100; tick("R11 read other");

    // Random mix: few numbers so entries collide often.
    for (int n = 0; n < 4000; n++) begin
      int r;
      gen_valid   = ($urandom_range(0, 9) < 4);
      gen_src     = CW'($urandom);
      gen_targets = NC'($urandom);
      gen_id      = SW'($urandom_range(0, 3));
      ack_valid   = ($urandom_range(0, 9) < 3);
      ack_cpu     = CW'($urandom);
      ack_id      = SW'($urandom_range(0, 3));
      r = $urandom_range(0, 9);
      reg_wr    = (r < 3);
      reg_rd    = (r >= 3 && r < 6);
      reg_cpu   = CW'($urandom);
      reg_wdata = 8'($urandom);
      r = $urandom_range(0, 9);
      if (r < 7)      reg_off = {8'hF1, 4'($urandom_range(0, 3))};
      else if (r < 8) reg_off = {8'hF0, 4'($urandom)};
      else            reg_off = 12'($urandom);
      tick("R1 R2 R3 R4 R6 R7 R8 R9 R11 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule